// File: doc/BRIEF.md
# Serial Register-Access Slave with Region-Aware Bursts

This block is the serial slave front end of a timekeeping peripheral. A host selects it with an active-high select line, clocks bits in on a data-in pin and reads bits back on a data-out pin. Behind the serial port sit two storage regions: a 32-byte scratch RAM and a bank of 19 clock/calendar registers. Both are modelled here as plain register arrays. Timekeeping itself is not part of the block.

Each selected transaction opens with a command byte. It carries the direction, a region choice and a five-bit start offset. Data bytes follow one at a time while select stays high. After each byte the offset advances, and it wraps to the start of the region it is in. The RAM wraps from offset 31 to offset 0. The clock bank wraps from address 0x32 back to 0x20. To start a transaction at a new address, the host drops select and raises it again. All pins are sampled on a faster system clock, and the block finds the serial-clock edges by comparing each sample with the one before.

Top module: `spi_regacc_slave`

## Requirements
- R1: After reset every RAM byte and every clock register reads 0x00, and `miso` is low.
- R2: The first byte after `sel` rises is the command byte. Bit 7 = 1 makes the transaction a write and bit 7 = 0 makes it a read. A one-byte transaction writes or returns the addressed byte.
- R3: Command bit 5 = 0 selects RAM and bit 5 = 1 selects the clock bank. Bits 4..0 give the start offset. RAM offset n and clock offset n are separate storage.
- R4: Bits travel MSB first. `mosi` is sampled on rising `sck` and `miso` changes only after a falling `sck` or while deselected. `miso` is low during the command byte and whenever `sel` is low.
- R5: Each further data byte in the same selection uses the next offset: a write stores it there, and a read returns the byte at that offset.
- R6: In RAM the offset after 0x1F is 0x00.
- R7: In the clock bank the address after 0x32 is 0x20.
- R8: A command byte with bit 6 = 1 makes the rest of the transaction ignored: nothing is written and `miso` stays low.
- R9: A write byte is stored only when all 8 bits have arrived. A partial byte cut off by `sel` falling changes nothing.
- R10: Clock-bank addresses 0x33 to 0x3F hold no storage. Writes to them are dropped and reads from them return 0x00. Bursts through them still advance, and 0x3F is followed by 0x20.
- R11: Dropping `sel` ends the burst. The first byte after `sel` rises again is decoded as a fresh command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Active-high slave select |
| sck | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
On every cycle the assertions check that `miso` moves only after a falling serial edge or while deselected, and that it goes low once select drops. They also check that an ignored transaction never raises the write strobe, and that the offset after 0x1F in RAM and after 0x32 in the clock bank comes back to the start of its region. The bench scenarios cover what only data read back through the port can show. This includes reset contents, MSB-first ordering, burst contents across both wraps, and dropped out-of-range writes. It also includes discarded partial bytes and a fresh command decode after reselection, all compared against a model of both regions kept inside the bench.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;
    localparam int DW       = 8;   // byte width
    localparam int OFF_W    = 5;   // offset field in the command byte
    localparam int RAM_N    = 1 << OFF_W;
    localparam int CLKREG_N = 19;  // clock bank entries, 0x20..0x32

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_SKIP = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e           phase;
        logic             wr;
        logic             region;  // 1: clock bank, 0: RAM
        logic [OFF_W-1:0] off;
    } ctl_t;
endpackage

// File: rtl/spi_regacc_sampler.sv
module spi_regacc_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_d, sck_q;

    always_comb begin
        sck_d = sck;
        rise  = sel & sck & ~sck_q;
        fall  = sel & ~sck & sck_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_d;
    end
endmodule

// File: rtl/spi_regacc_shifter.sv
module spi_regacc_shifter
    import spi_regacc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rise,
    input  logic          fall,
    input  logic          mosi,
    input  logic          load_en,
    input  logic [DW-1:0] load_data,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte,
    output logic          tx_slot,
    output logic          miso
);
    localparam int CNT_W = $clog2(DW);

    typedef struct packed {
        logic [CNT_W-1:0] bitcnt;
        logic [DW-1:0]    rx;
        logic [DW-1:0]    tx;
        logic             got;  // a whole byte has arrived in this selection
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        byte_done = 1'b0;
        tx_slot   = 1'b0;
        rx_byte   = {s_q.rx[DW-2:0], mosi};
        if (!sel) begin
            s_d = '0;
        end else if (rise) begin
            s_d.rx     = {s_q.rx[DW-2:0], mosi};
            s_d.bitcnt = s_q.bitcnt + 1'b1;
            if (s_q.bitcnt == CNT_W'(DW - 1)) begin
                byte_done = 1'b1;
                s_d.got   = 1'b1;
            end
        end else if (fall) begin
            if (s_q.bitcnt == '0 && s_q.got) begin
                tx_slot = 1'b1;
                s_d.tx  = load_en ? load_data : '0;
            end else begin
                s_d.tx = {s_q.tx[DW-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign miso = s_q.tx[DW-1];
endmodule

// File: rtl/spi_regacc_bank.sv
module spi_regacc_bank
    import spi_regacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             region,
    input  logic [OFF_W-1:0] off,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] ram_d [RAM_N];
    logic [DW-1:0] ram_q [RAM_N];
    logic [DW-1:0] cr_d  [CLKREG_N];
    logic [DW-1:0] cr_q  [CLKREG_N];

    logic in_bank;
    assign in_bank = int'(off) < CLKREG_N;

    always_comb begin
        ram_d = ram_q;
        cr_d  = cr_q;
        if (we && !region) ram_d[off] = wdata;
        for (int i = 0; i < CLKREG_N; i++) begin
            if (we && region && int'(off) == i) cr_d[i] = wdata;
        end
        rdata = '0;
        if (!region) begin
            rdata = ram_q[off];
        end else if (in_bank) begin
            for (int i = 0; i < CLKREG_N; i++) begin
                if (int'(off) == i) rdata = cr_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_N; i++)    ram_q[i] <= '0;
            for (int i = 0; i < CLKREG_N; i++) cr_q[i]  <= '0;
        end else begin
            ram_q <= ram_d;
            cr_q  <= cr_d;
        end
    end
endmodule

// File: rtl/spi_regacc_slave.sv
module spi_regacc_slave
    import spi_regacc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    localparam logic [OFF_W-1:0] CLK_LAST = OFF_W'(CLKREG_N - 1);

    logic          rise, fall, byte_done, tx_slot, load_en, we;
    logic [DW-1:0] rx_byte, rdata;
    ctl_t          c_d, c_q;

    function automatic logic [OFF_W-1:0] next_off(input logic region,
                                                  input logic [OFF_W-1:0] off);
        if (region && off == CLK_LAST) return '0;
        return off + 1'b1;
    endfunction

    spi_regacc_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sck(sck),
        .rise(rise), .fall(fall)
    );

    spi_regacc_shifter u_shf (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rise(rise), .fall(fall),
        .mosi(mosi), .load_en(load_en), .load_data(rdata),
        .byte_done(byte_done), .rx_byte(rx_byte), .tx_slot(tx_slot),
        .miso(miso)
    );

    spi_regacc_bank u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .region(c_q.region),
        .off(c_q.off), .wdata(rx_byte), .rdata(rdata)
    );

    always_comb begin
        c_d     = c_q;
        we      = 1'b0;
        load_en = 1'b0;
        if (!sel) begin
            c_d.phase = PH_CMD;
        end else if (byte_done && c_q.phase == PH_CMD) begin
            c_d.wr     = rx_byte[7];
            c_d.region = rx_byte[5];
            c_d.off    = rx_byte[OFF_W-1:0];
            c_d.phase  = rx_byte[6] ? PH_SKIP : PH_DATA;
        end else if (byte_done && c_q.phase == PH_DATA && c_q.wr) begin
            we      = 1'b1;
            c_d.off = next_off(c_q.region, c_q.off);
        end else if (tx_slot && c_q.phase == PH_DATA && !c_q.wr) begin
            load_en = 1'b1;
            c_d.off = next_off(c_q.region, c_q.off);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{phase: PH_CMD, wr: 1'b0, region: 1'b0, off: '0};
        else        c_q <= c_d;
    end

    // R4: output idles low once select is dropped
    p_miso_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !miso);
    // R4: output moves only after a falling serial edge or deselect
    p_miso_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> ($past(fall) || !$past(sel)));
    // R8: an ignored transaction never reaches storage
    p_skip_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase == PH_SKIP) |-> !we);
    // R6: RAM offset after the last byte is the first
    p_ram_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we || load_en) && !c_q.region && c_q.off == '1 |=> c_q.off == '0);
    // R7: clock bank wraps from its last register to its first
    p_clk_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we || load_en) && c_q.region && c_q.off == CLK_LAST |=> c_q.off == '0);
endmodule

// File: tb/spi_regacc_slave_test.sv
module spi_regacc_slave_test;
    localparam int H = 4;  // system clocks per serial half period

    logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, sck = 1'b0, mosi = 1'b0;
    logic miso;
    int   n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] m_ram [32];
    logic [7:0] m_clk [19];

    always #2 clk = ~clk;  // 250 MHz

    spi_regacc_slave uut (.clk(clk), .rst_n(rst_n), .sel(sel), .sck(sck),
                          .mosi(mosi), .miso(miso));

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=hung exp=done");
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_start();
        @(negedge clk); sel = 1'b1; wait_n(H);
    endtask

    task automatic t_end();
        wait_n(H); sel = 1'b0; sck = 1'b0; wait_n(2 * H);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = tx[i];
            wait_n(H);
            rx[i] = miso;
            sck = 1'b1;
            wait_n(H);
            sck = 1'b0;
        end
    endtask

    function automatic logic [4:0] m_next(input logic reg_c, input logic [4:0] off);
        if (reg_c && off == 5'd18) return 5'd0;
        return off + 5'd1;
    endfunction

    function automatic logic [7:0] m_read(input logic reg_c, input logic [4:0] off);
        if (!reg_c) return m_ram[off];
        if (off < 5'd19) return m_clk[off];
        return 8'h00;
    endfunction

    // write burst: byte k = base + k*step
    task automatic wr_burst(input logic [7:0] cmd, input int n, input int base, input int step);
        logic [7:0] rx;
        logic [4:0] off = cmd[4:0];
        t_start();
        xfer_bits(cmd, 8, rx);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v = 8'(base + k * step);
            xfer_bits(v, 8, rx);
            if (!cmd[6]) begin
                if (!cmd[5]) m_ram[off] = v;
                else if (off < 5'd19) m_clk[off] = v;
                off = m_next(cmd[5], off);
            end
        end
        t_end();
    endtask

    task automatic rd_check(input logic [7:0] cmd, input int n, input string req);
        logic [7:0] rx;
        logic [4:0] off = cmd[4:0];
        t_start();
        xfer_bits(cmd, 8, rx);
        check(rx == 8'h00, "R4 miso low in command byte", rx, 0);
        for (int k = 0; k < n; k++) begin
            logic [7:0] e = cmd[6] ? 8'h00 : m_read(cmd[5], off);
            xfer_bits(8'h00, 8, rx);
            check(rx == e, req, rx, e);
            off = m_next(cmd[5], off);
        end
        t_end();
    endtask

    initial begin
        logic [7:0] rx;
        for (int i = 0; i < 32; i++) m_ram[i] = '0;
        for (int i = 0; i < 19; i++) m_clk[i] = '0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        check(miso == 1'b0, "R1 miso after reset", miso, 0);

        // R1: reset contents of both regions
        rd_check(8'h00, 32, "R1 RAM reset value");
        rd_check(8'h20, 19, "R1 clock reset value");

        // R2 R3: single-byte write then read, per region
        wr_burst(8'h85, 1, 8'h5A, 0);
        wr_burst(8'hA5, 1, 8'hC3, 0);
        rd_check(8'h05, 1, "R2 single read RAM");
        rd_check(8'h25, 1, "R3 single read clock distinct");

        // R5 R6: RAM burst through the wrap, then read across it
        wr_burst(8'h80, 35, 11, 37);
        rd_check(8'h1D, 36, "R6 RAM burst wrap read");
        rd_check(8'h00, 32, "R5 RAM burst read");

        // R7: clock burst through its wrap
        wr_burst(8'hA0, 21, 7, 53);
        rd_check(8'h30, 6, "R7 clock wrap read");
        rd_check(8'h20, 19, "R5 clock burst read");

        // R10: out-of-range clock addresses
        wr_burst(8'hB5, 1, 8'hEE, 0);
        wr_burst(8'hBE, 3, 8'h11, 8'h11);
        rd_check(8'h3E, 3, "R10 out-of-range read and wrap");
        rd_check(8'h20, 19, "R10 clock bank after dropped writes");

        // R8: bit 6 set ignores the whole transaction
        wr_burst(8'hC3, 2, 8'hAA, 8'h55);
        wr_burst(8'hE1, 2, 8'hAA, 8'h55);
        rd_check(8'h43, 2, "R8 ignored read keeps miso low");
        rd_check(8'h00, 32, "R8 RAM unchanged");
        rd_check(8'h20, 19, "R8 clock unchanged");

        // R9: partial byte discarded
        t_start();
        xfer_bits(8'h84, 8, rx);
        xfer_bits(8'hFF, 4, rx);
        t_end();
        rd_check(8'h04, 1, "R9 partial byte discarded");
        t_start();
        xfer_bits(8'h86, 8, rx);
        xfer_bits(8'h3C, 8, rx);
        xfer_bits(8'hFF, 5, rx);
        t_end();
        m_ram[6] = 8'h3C;
        rd_check(8'h06, 2, "R9 whole byte kept, tail dropped");

        // R11: reselect decodes a fresh command
        wr_burst(8'h88, 1, 8'h77, 0);
        wr_burst(8'h88, 1, 8'h66, 0);
        rd_check(8'h08, 2, "R11 fresh command after reselect");
        check(miso == 1'b0, "R4 miso idle while deselected", miso, 0);

        summary();
    end
endmodule